// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each clock cycle it takes one opcode, two 16-bit operands and a target select. It then updates one of two 40-bit accumulators. The possible updates are:

- a product, or its negation;
- a running sum or difference of products;
- a square, or a running sum of squares;
- the square of the operand difference, or a running sum of those;
- an add, subtract or negate between the two accumulators.

Each operand passes through a 17-bit extension stage, so signed and unsigned 16-bit data use one multiplier. An optional fractional mode doubles the product, so that 1.15 by 1.15 gives a 1.31 result. The eight guard bits above bit 31 let long sums grow without wrapping. Each accumulator has its own clamp to the signed 32-bit range and a sticky flag that records each clamp.

A combinational store path turns either accumulator into a 16-bit word. It rounds at bit 15, using either round-half-up or round-half-to-even, takes bits 31:16, and can clamp the result to the 16-bit signed limits. Operand fetch and shifting belong to surrounding logic.

Top module: `mac_engine`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators and both saturation flags become zero.
- R2: Opcode 0 (hold) and codes 13 to 15 change nothing. Opcode 1 (clear) sets the accumulator picked by `acc_sel` (0 = A, 1 = B) to zero and clears its flag. No opcode changes the accumulator that is not picked.
- R3: Opcodes 2 (load x·y), 3 (load −x·y), 4 (add x·y) and 5 (subtract x·y) work on the target. With `signed_mode` = 1, operands are sign-extended. With `signed_mode` = 0, operands are zero-extended.
- R4: With `frac_mode` = 1, every product is doubled before it is sign-extended to 40 bits and used.
- R5: Opcode 6 loads x·x and opcode 7 adds x·x. The y operand is ignored for both.
- R6: Opcode 8 loads (x−y)² and opcode 9 adds (x−y)². The difference uses the extended operands.
- R7: Opcode 10 sets target = target + other. Opcode 11 sets target = target − other. Opcode 12 sets target = −target.
- R8: When a write to accumulator A goes past the signed 32-bit range and `sat_en_a` is 1, the result becomes 0x007FFFFFFF or 0xFF80000000. The same holds for B with `sat_en_b`. With the enable at 0, the 40-bit result is kept.
- R9: A clamp sets that accumulator's flag. The flag stays set until a clear opcode on that accumulator or a reset.
- R10: `store_data` is bits 31:16 of the accumulator picked by `store_sel` after 0x8000 is added. This is the rounding used when `round_even` = 0.
- R11: With `round_even` = 1, when bits 15:0 are exactly 0x8000 and bit 16 is 0, nothing is added. Every other case rounds as in R10.
- R12: With `sat_wr_en` = 1, a rounded value above 0x7FFFFFFF gives a store of 0x7FFF. A rounded value below −2^31 gives a store of 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Opcode (see R2–R7) |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| frac_mode | input | 1 | 1 = fractional (product doubled) |
| signed_mode | input | 1 | 1 = signed operands, 0 = unsigned |
| round_even | input | 1 | 1 = round half to even on store |
| sat_en_a | input | 1 | Clamp enable for accumulator A |
| sat_en_b | input | 1 | Clamp enable for accumulator B |
| sat_wr_en | input | 1 | Clamp enable for the 16-bit store value |
| store_sel | input | 1 | Accumulator feeding the store path: 0 = A, 1 = B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| sat_flag_a | output | 1 | Sticky clamp flag of A |
| sat_flag_b | output | 1 | Sticky clamp flag of B |
| store_data | output | 16 | Rounded, optionally clamped store word |

## Verification
Both accumulators are ports, so a wrong product, extension, sign or clamp shows up in the cycle right after the opcode that caused it. An error in the guard bits may stay hidden in bits 31:16 until later sums move it into the range that `store_data` shows. Rounding and store clamping are combinational from the registered accumulators and the mode inputs, so a fault there appears as soon as those inputs change. A stuck or leaking saturation flag appears on the next write to either accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int ACC_W_DEF  = 40;

    typedef enum logic [3:0] {
        OP_HOLD  = 4'd0,
        OP_CLR   = 4'd1,
        OP_MPY   = 4'd2,
        OP_MPYN  = 4'd3,
        OP_MAC   = 4'd4,
        OP_MSC   = 4'd5,
        OP_SQR   = 4'd6,
        OP_SQRAC = 4'd7,
        OP_DSQ   = 4'd8,
        OP_DSQAC = 4'd9,
        OP_ADD   = 4'd10,
        OP_SUB   = 4'd11,
        OP_NEG   = 4'd12
    } mac_op_e;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_PROD  = 2'd1,
        SRC_OTHER = 2'd2,
        SRC_SELF  = 2'd3
    } addend_src_e;

    typedef struct packed {
        logic        wr;
        logic        base_self;
        addend_src_e src;
        logic        neg;
        logic        square;
        logic        diff;
        logic        clr_flag;
    } mac_ctl_t;

    function automatic mac_ctl_t decode_op(input mac_op_e code);
        mac_ctl_t c;
        c = '{wr: 1'b0, base_self: 1'b0, src: SRC_ZERO, neg: 1'b0,
              square: 1'b0, diff: 1'b0, clr_flag: 1'b0};
        case (code)
            OP_CLR:   begin c.wr = 1'b1; c.clr_flag = 1'b1; end
            OP_MPY:   begin c.wr = 1'b1; c.src = SRC_PROD; end
            OP_MPYN:  begin c.wr = 1'b1; c.src = SRC_PROD; c.neg = 1'b1; end
            OP_MAC:   begin c.wr = 1'b1; c.src = SRC_PROD; c.base_self = 1'b1; end
            OP_MSC:   begin c.wr = 1'b1; c.src = SRC_PROD; c.base_self = 1'b1; c.neg = 1'b1; end
            OP_SQR:   begin c.wr = 1'b1; c.src = SRC_PROD; c.square = 1'b1; end
            OP_SQRAC: begin c.wr = 1'b1; c.src = SRC_PROD; c.square = 1'b1; c.base_self = 1'b1; end
            OP_DSQ:   begin c.wr = 1'b1; c.src = SRC_PROD; c.diff = 1'b1; end
            OP_DSQAC: begin c.wr = 1'b1; c.src = SRC_PROD; c.diff = 1'b1; c.base_self = 1'b1; end
            OP_ADD:   begin c.wr = 1'b1; c.src = SRC_OTHER; c.base_self = 1'b1; end
            OP_SUB:   begin c.wr = 1'b1; c.src = SRC_OTHER; c.base_self = 1'b1; c.neg = 1'b1; end
            OP_NEG:   begin c.wr = 1'b1; c.src = SRC_SELF; c.neg = 1'b1; end
            default:  c.wr = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = mac_pkg::DATA_W_DEF,
    parameter int ACC_W  = mac_pkg::ACC_W_DEF
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              signed_mode,
    input  logic              frac_mode,
    input  logic              square,
    input  logic              diff,
    output logic [ACC_W-1:0]  prod
);
    localparam int MUL_W  = DATA_W + 1;
    localparam int PROD_W = 2 * MUL_W;
    localparam int EXT_W  = ACC_W - PROD_W - 1;

    logic signed [MUL_W-1:0]  ext_x, ext_y, delta, fac_a, fac_b;
    logic signed [PROD_W-1:0] raw;
    logic        [PROD_W:0]   scaled;

    always_comb begin
        ext_x = {signed_mode & x[DATA_W-1], x};
        ext_y = {signed_mode & y[DATA_W-1], y};
        // difference of two extended operands always fits MUL_W bits signed
        delta = ext_x - ext_y;
        fac_a = diff ? delta : ext_x;
        fac_b = diff ? delta : (square ? ext_x : ext_y);
        raw   = fac_a * fac_b;
        scaled = frac_mode ? {raw, 1'b0} : {raw[PROD_W-1], raw};
        prod  = {{EXT_W{scaled[PROD_W]}}, scaled};
    end
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
    parameter int ACC_W = mac_pkg::ACC_W_DEF,
    parameter int SAT_W = 2 * mac_pkg::DATA_W_DEF
) (
    input  logic [ACC_W-1:0] base,
    input  logic [ACC_W-1:0] addend,
    input  logic             negate,
    input  logic             sat_en,
    output logic [ACC_W-1:0] result,
    output logic             sat_hit
);
    localparam int PAD_W = ACC_W - SAT_W + 2;
    localparam logic signed [ACC_W:0] POS_LIM = {{PAD_W{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] NEG_LIM = {{PAD_W{1'b1}}, {(SAT_W-1){1'b0}}};

    logic signed [ACC_W:0] b_ext, a_ext, sum;
    logic                  above, below;

    always_comb begin
        b_ext = {base[ACC_W-1], base};
        a_ext = {addend[ACC_W-1], addend};
        sum   = negate ? (b_ext - a_ext) : (b_ext + a_ext);
        above = sum > POS_LIM;
        below = sum < NEG_LIM;
        if (sat_en && above)      result = POS_LIM[ACC_W-1:0];
        else if (sat_en && below) result = NEG_LIM[ACC_W-1:0];
        else                      result = sum[ACC_W-1:0];
        sat_hit = sat_en & (above | below);
    end
endmodule

// File: rtl/mac_store.sv
module mac_store #(
    parameter int DATA_W = mac_pkg::DATA_W_DEF,
    parameter int ACC_W  = mac_pkg::ACC_W_DEF
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic              round_even,
    input  logic              sat_wr_en,
    output logic [DATA_W-1:0] data
);
    localparam int SAT_W = 2 * DATA_W;
    localparam int PAD_W = ACC_W - SAT_W + 2;
    localparam logic signed [ACC_W:0] POS_LIM = {{PAD_W{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [ACC_W:0] NEG_LIM = {{PAD_W{1'b1}}, {(SAT_W-1){1'b0}}};
    localparam logic [ACC_W:0]        HALF    = (ACC_W+1)'(1) << (DATA_W-1);
    localparam logic [DATA_W-1:0]     TIE     = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0]     MAX_W   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0]     MIN_W   = {1'b1, {(DATA_W-1){1'b0}}};

    logic                  keep_even;
    logic signed [ACC_W:0] rounded;

    always_comb begin
        keep_even = round_even && (acc[DATA_W-1:0] == TIE) && !acc[DATA_W];
        rounded   = {acc[ACC_W-1], acc} + (keep_even ? '0 : HALF);
        if (sat_wr_en && (rounded > POS_LIM))      data = MAX_W;
        else if (sat_wr_en && (rounded < NEG_LIM)) data = MIN_W;
        else                                       data = rounded[SAT_W-1:DATA_W];
    end
endmodule

// File: rtl/mac_engine.sv
module mac_engine
    import mac_pkg::*;
#(
    parameter int DATA_W = mac_pkg::DATA_W_DEF,
    parameter int ACC_W  = mac_pkg::ACC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              frac_mode,
    input  logic              signed_mode,
    input  logic              round_even,
    input  logic              sat_en_a,
    input  logic              sat_en_b,
    input  logic              sat_wr_en,
    input  logic              store_sel,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic              sat_flag_a,
    output logic              sat_flag_b,
    output logic [DATA_W-1:0] store_data
);
    localparam int SAT_W   = 2 * DATA_W;
    localparam int NUM_ACC = 2;

    mac_ctl_t           ctl;
    logic [ACC_W-1:0]   acc_q [NUM_ACC];
    logic               flag_q [NUM_ACC];
    logic [ACC_W-1:0]   self_v, other_v, base_v, addend_v, prod_v, sum_v, store_src;
    logic               sat_sel, hit;

    assign ctl = decode_op(mac_op_e'(op));

    always_comb begin
        self_v  = acc_sel ? acc_q[1] : acc_q[0];
        other_v = acc_sel ? acc_q[0] : acc_q[1];
        sat_sel = acc_sel ? sat_en_b : sat_en_a;
        base_v  = ctl.base_self ? self_v : '0;
        case (ctl.src)
            SRC_PROD:  addend_v = prod_v;
            SRC_OTHER: addend_v = other_v;
            SRC_SELF:  addend_v = self_v;
            default:   addend_v = '0;
        endcase
    end

    mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
        .x(x), .y(y), .signed_mode(signed_mode), .frac_mode(frac_mode),
        .square(ctl.square), .diff(ctl.diff), .prod(prod_v)
    );

    mac_addsat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_addsat (
        .base(base_v), .addend(addend_v), .negate(ctl.neg), .sat_en(sat_sel),
        .result(sum_v), .sat_hit(hit)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ACC; i++) begin
            if (rst) begin
                acc_q[i]  <= '0;
                flag_q[i] <= 1'b0;
            end else if (ctl.wr && (acc_sel == 1'(i))) begin
                acc_q[i]  <= sum_v;
                flag_q[i] <= ctl.clr_flag ? 1'b0 : (flag_q[i] | hit);
            end
        end
    end

    assign store_src = store_sel ? acc_q[1] : acc_q[0];

    mac_store #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_store (
        .acc(store_src), .round_even(round_even), .sat_wr_en(sat_wr_en),
        .data(store_data)
    );

    assign acc_a      = acc_q[0];
    assign acc_b      = acc_q[1];
    assign sat_flag_a = flag_q[0];
    assign sat_flag_b = flag_q[1];
endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op,
    input logic              acc_sel,
    input logic              sat_en_a,
    input logic              sat_wr_en,
    input logic              store_sel,
    input logic [ACC_W-1:0]  acc_a,
    input logic [ACC_W-1:0]  acc_b,
    input logic              sat_flag_a,
    input logic [DATA_W-1:0] store_data
);
    localparam int SAT_W = 2 * DATA_W;

    logic       is_write;
    logic [ACC_W-1:0] st_acc;
    assign is_write = (op >= 4'd1) && (op <= 4'd12);
    assign st_acc   = store_sel ? acc_b : acc_a;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_a == '0 && acc_b == '0 && !sat_flag_a));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd0) |=> ($stable(acc_a) && $stable(acc_b)));

    // R2
    other_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_sel == 1'b0) |=> $stable(acc_b));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd1 && acc_sel == 1'b0) |=> (acc_a == '0 && !sat_flag_a));

    // R8
    sat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (is_write && acc_sel == 1'b0 && sat_en_a) |=>
        ((acc_a[ACC_W-1:SAT_W-1] == '0) || (acc_a[ACC_W-1:SAT_W-1] == '1)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag_a && !(op == 4'd1 && acc_sel == 1'b0)) |=> sat_flag_a);

    // R12
    store_pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_wr_en && !st_acc[ACC_W-1] && (|st_acc[ACC_W-2:SAT_W-1])) |->
        (store_data == {1'b0, {(DATA_W-1){1'b1}}}));
endmodule

bind mac_engine mac_engine_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst(rst), .op(op), .acc_sel(acc_sel), .sat_en_a(sat_en_a),
    .sat_wr_en(sat_wr_en), .store_sel(store_sel), .acc_a(acc_a), .acc_b(acc_b),
    .sat_flag_a(sat_flag_a), .store_data(store_data)
);

// File: tb/mac_engine_test.sv
`timescale 1ns/1ps
module mac_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic        acc_sel = 1'b0;
    logic [15:0] x = '0, y = '0;
    logic        frac_mode = 1'b0, signed_mode = 1'b1, round_even = 1'b0;
    logic        sat_en_a = 1'b0, sat_en_b = 1'b0, sat_wr_en = 1'b0, store_sel = 1'b0;
    logic [39:0] acc_a, acc_b;
    logic        sat_flag_a, sat_flag_b;
    logic [15:0] store_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mac_engine uut (
        .clk(clk), .rst(rst), .op(op), .acc_sel(acc_sel), .x(x), .y(y),
        .frac_mode(frac_mode), .signed_mode(signed_mode), .round_even(round_even),
        .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_wr_en(sat_wr_en),
        .store_sel(store_sel), .acc_a(acc_a), .acc_b(acc_b),
        .sat_flag_a(sat_flag_a), .sat_flag_b(sat_flag_b), .store_data(store_data)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%010h expected 0x%010h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic s,
                          input logic [15:0] a, input logic [15:0] b);
        op = o; acc_sel = s; x = a; y = b;
        @(posedge clk);
        #1;
        op = 4'd0;
    endtask

    task automatic t_reset;
        chk("R1 acc_a", acc_a, 40'd0);
        chk("R1 acc_b", acc_b, 40'd0);
        chk("R1 flags", {38'd0, sat_flag_a, sat_flag_b}, 40'd0);
        chk("R10 store after reset", {24'd0, store_data}, 40'd0);
    endtask

    task automatic t_signed_int;
        signed_mode = 1'b1; frac_mode = 1'b0;
        run_op(4'd2, 1'b0, 16'hFFFD, 16'd7);
        chk("R3 mpy -3*7", acc_a, 40'hFFFFFFFFEB);
        chk("R2 B untouched", acc_b, 40'd0);
        run_op(4'd4, 1'b0, 16'd100, 16'hFFFE);
        chk("R3 mac", acc_a, 40'hFFFFFFFF23);
        run_op(4'd5, 1'b0, 16'hFFF6, 16'd10);
        chk("R3 msc", acc_a, 40'hFFFFFFFF87);
        run_op(4'd3, 1'b1, 16'd5, 16'd6);
        chk("R3 mpyn", acc_b, 40'hFFFFFFFFE2);
        chk("R2 A untouched", acc_a, 40'hFFFFFFFF87);
        run_op(4'd0, 1'b0, 16'h1234, 16'h5678);
        chk("R2 hold", acc_a, 40'hFFFFFFFF87);
        run_op(4'd15, 1'b1, 16'h1234, 16'h5678);
        chk("R2 undefined code", acc_b, 40'hFFFFFFFFE2);
        run_op(4'd2, 1'b1, 16'hFFFF, 16'hFFFF);
        chk("R3 signed -1*-1", acc_b, 40'd1);
    endtask

    task automatic t_frac;
        signed_mode = 1'b1; frac_mode = 1'b1;
        run_op(4'd2, 1'b0, 16'h4000, 16'h4000);
        chk("R4 frac 0.5*0.5", acc_a, 40'h0020000000);
        run_op(4'd4, 1'b0, 16'h8000, 16'h4000);
        chk("R4 frac mac -1*0.5", acc_a, 40'hFFE0000000);
        frac_mode = 1'b0;
    endtask

    task automatic t_unsigned;
        signed_mode = 1'b0;
        run_op(4'd2, 1'b0, 16'hFFFF, 16'hFFFF);
        chk("R3 unsigned mpy", acc_a, 40'h00FFFE0001);
        chk("R8 no clamp when off", {39'd0, sat_flag_a}, 40'd0);
        sat_en_b = 1'b1;
        run_op(4'd2, 1'b1, 16'hFFFF, 16'hFFFF);
        chk("R8 clamp high B", acc_b, 40'h007FFFFFFF);
        chk("R9 flag B set", {39'd0, sat_flag_b}, 40'd1);
        run_op(4'd1, 1'b1, 16'hFFFF, 16'hFFFF);
        chk("R2 clear B", acc_b, 40'd0);
        chk("R2 clear flag B", {39'd0, sat_flag_b}, 40'd0);
        sat_en_b = 1'b0;
        signed_mode = 1'b1;
    endtask

    task automatic t_square;
        signed_mode = 1'b1;
        run_op(4'd6, 1'b0, 16'hFED4, 16'h1234);
        chk("R5 square", acc_a, 40'h0000015F90);
        run_op(4'd7, 1'b0, 16'd4, 16'h7777);
        chk("R5 square acc", acc_a, 40'h0000015FA0);
        run_op(4'd8, 1'b1, 16'd10, 16'hFFFB);
        chk("R6 diff square", acc_b, 40'h00000000E1);
        run_op(4'd9, 1'b1, 16'hFFF9, 16'd3);
        chk("R6 diff square acc", acc_b, 40'h0000000145);
        signed_mode = 1'b0;
        run_op(4'd8, 1'b0, 16'd0, 16'hFFFF);
        chk("R6 unsigned diff square", acc_a, 40'h00FFFE0001);
        signed_mode = 1'b1;
    endtask

    task automatic t_accops;
        signed_mode = 1'b1;
        run_op(4'd2, 1'b0, 16'd1000, 16'd1000);
        run_op(4'd2, 1'b1, 16'd7, 16'hFFFF);
        run_op(4'd10, 1'b0, 16'h0, 16'h0);
        chk("R7 add", acc_a, 40'h00000F4239);
        run_op(4'd11, 1'b1, 16'h0, 16'h0);
        chk("R7 sub", acc_b, 40'hFFFFF0BDC0);
        run_op(4'd12, 1'b0, 16'h0, 16'h0);
        chk("R7 neg", acc_a, 40'hFFFFF0BDC7);
        chk("R7 neg leaves other", acc_b, 40'hFFFFF0BDC0);
    endtask

    task automatic t_sat;
        signed_mode = 1'b0;
        run_op(4'd2, 1'b0, 16'hFFFF, 16'h8000);
        run_op(4'd2, 1'b1, 16'hFFFF, 16'h8000);
        sat_en_a = 1'b1;
        run_op(4'd10, 1'b0, 16'h0, 16'h0);
        chk("R8 add clamp high", acc_a, 40'h007FFFFFFF);
        chk("R9 flag A set", {39'd0, sat_flag_a}, 40'd1);
        signed_mode = 1'b1;
        run_op(4'd3, 1'b0, 16'h8000, 16'h8000);
        chk("R3 mpyn in range", acc_a, 40'hFFC0000000);
        chk("R9 flag A sticky", {39'd0, sat_flag_a}, 40'd1);
        run_op(4'd5, 1'b0, 16'h8000, 16'h8000);
        chk("R8 exact minimum kept", acc_a, 40'hFF80000000);
        run_op(4'd5, 1'b0, 16'd1, 16'd1);
        chk("R8 clamp low", acc_a, 40'hFF80000000);
        sat_en_a = 1'b0;
        run_op(4'd5, 1'b0, 16'd1, 16'd1);
        chk("R8 guard bits used when off", acc_a, 40'hFF7FFFFFFF);
        run_op(4'd1, 1'b0, 16'd0, 16'd0);
        chk("R9 flag cleared by clear", {39'd0, sat_flag_a}, 40'd0);
    endtask

    task automatic t_round;
        signed_mode = 1'b0; store_sel = 1'b0; sat_wr_en = 1'b0;
        run_op(4'd2, 1'b0, 16'd3, 16'h8000);
        round_even = 1'b0; #1;
        chk("R10 tie odd half-up", {24'd0, store_data}, 40'h2);
        round_even = 1'b1; #1;
        chk("R11 tie odd to even", {24'd0, store_data}, 40'h2);
        run_op(4'd2, 1'b0, 16'd1, 16'h8000);
        round_even = 1'b0; #1;
        chk("R10 tie even half-up", {24'd0, store_data}, 40'h1);
        round_even = 1'b1; #1;
        chk("R11 tie even kept", {24'd0, store_data}, 40'h0);
        run_op(4'd2, 1'b0, 16'h8001, 16'd1);
        chk("R11 above tie", {24'd0, store_data}, 40'h1);
        run_op(4'd2, 1'b1, 16'd5, 16'h8000);
        store_sel = 1'b1; round_even = 1'b0; #1;
        chk("R10 store from B", {24'd0, store_data}, 40'h3);
        store_sel = 1'b0;
        signed_mode = 1'b1;
    endtask

    task automatic t_wrsat;
        signed_mode = 1'b0; round_even = 1'b0; store_sel = 1'b0;
        run_op(4'd2, 1'b0, 16'hFFFF, 16'hFFFF);
        sat_wr_en = 1'b0; #1;
        chk("R12 no store clamp", {24'd0, store_data}, 40'hFFFE);
        sat_wr_en = 1'b1; #1;
        chk("R12 store clamp high", {24'd0, store_data}, 40'h7FFF);
        run_op(4'd3, 1'b0, 16'hFFFF, 16'hFFFF);
        chk("R3 unsigned mpyn", acc_a, 40'hFF0001FFFF);
        sat_wr_en = 1'b0; #1;
        chk("R12 no store clamp low", {24'd0, store_data}, 40'h0002);
        sat_wr_en = 1'b1; #1;
        chk("R12 store clamp low", {24'd0, store_data}, 40'h8000);
        sat_wr_en = 1'b0;
        signed_mode = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        t_signed_int();
        t_frac();
        t_unsigned();
        t_square();
        t_accops();
        t_sat();
        t_round();
        t_wrsat();
        rst = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule